// File: doc/BRIEF.md
# Hardware Cursor Overlay Pixel Mixer

This block is the streaming pixel stage of an indexed-colour display. A pulse on `frame_go` starts a raster scan of `width` by `height` positions, one per clock, in line order. For each position the block reads one 8-bit colour index from frame memory. The read starts at a top-of-screen offset and moves linearly through memory. The block looks the index up in a 256-entry colour palette and sends out a 24-bit RGB pixel with an aligned valid strobe and its raster coordinates.

A 64×64 hardware cursor can be laid over the image. Its shape is a two-bit-per-pixel pattern, packed eight pixels to a 16-bit word. Code 0 is transparent. Codes 1 to 3 replace the pixel with one of three cursor colours. A disable input removes the cursor and a blank input turns every pixel black. One clock after the last pixel of a frame the block gives a one-cycle frame interrupt pulse.

Frame memory, colour palette and cursor pattern are synchronous RAMs owned by the register bank. Each has a read port with one cycle of latency. The three cursor colours arrive as a flat vector.

Top module: `ovl_cursor_mixer`

## Requirements
- R1: After reset `out_valid` and `frame_irq` are low, and they stay low until a frame is started.
- R2: A frame visits positions with x fastest, one per clock. `fb_addr` is `top_offset + y*width + x` modulo 2^AW. `out_x`/`out_y` carry the coordinates of each emitted pixel.
- R3: A pixel outside the cursor window takes the colour-palette entry addressed by its frame-memory byte, with `pal_addr` equal to that byte.
- R4: The cursor window is `cursor_x <= x < cursor_x+64` and `cursor_y <= y < cursor_y+64`, with no wraparound. Inside the window, code 0 leaves the palette colour unchanged.
- R5: Inside the window the pattern word is at `pat_addr = (y-cursor_y)*8 + (x-cursor_x)/8`. The code is held in bits `((x-cursor_x) mod 8)*2 +: 2` of that word. A code c in 1..3 gives cursor colour c-1, held in `cur_colors[24*(c-1) +: 24]`.
- R6: With `cursor_off` set, every pixel is the palette colour of its byte.
- R7: With `force_blank` set, every pixel is emitted with `out_valid` high and `out_rgb` equal to 0.
- R8: `frame_irq` is high for exactly one cycle, the cycle after the last pixel of a frame is emitted.
- R9: `frame_go` with `width` or `height` zero starts nothing: no pixel and no interrupt follow.
- R10: The block samples `width`, `height`, `top_offset`, cursor position, `cursor_off` and `force_blank` on the `frame_go` edge that starts a frame. A `frame_go` that arrives while a frame is being scanned is ignored.
- R11: The first pixel appears with `out_valid` after the third rising edge following the edge that samples `frame_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_go | input | 1 | Start-of-frame request |
| width | input | XW | Pixels per line |
| height | input | YW | Lines per frame |
| top_offset | input | AW | Frame-memory address of the first pixel |
| cursor_x | input | XW | Left column of the cursor window |
| cursor_y | input | YW | Top line of the cursor window |
| cursor_off | input | 1 | Removes the cursor when set |
| force_blank | input | 1 | Forces black pixels when set |
| cur_colors | input | 72 | Three 24-bit cursor colours, entry i at bits 24*i |
| fb_addr | output | AW | Frame-memory read address |
| fb_data | input | 8 | Frame-memory byte, one cycle after the address |
| pat_addr | output | 9 | Cursor pattern read address |
| pat_data | input | 16 | Cursor pattern word, one cycle after the address |
| pal_addr | output | 8 | Colour-palette read address |
| pal_data | input | 24 | Palette RGB, one cycle after the address |
| out_valid | output | 1 | Pixel strobe |
| out_x | output | XW | Column of the emitted pixel |
| out_y | output | YW | Line of the emitted pixel |
| out_rgb | output | 24 | Emitted pixel colour |
| frame_irq | output | 1 | End-of-frame pulse |

## Verification
The assertions check on every cycle that frame-memory addresses step by exactly one while a scan runs. They also check that emitted columns step by one within a line, that a zero-sized request never starts a scan, and that the interrupt is a single pulse that only follows a pixel strobe. The colour chosen for each pixel can only be shown by the bench's scenarios. So can the clipping of the cursor at the window edges and at the screen edge, the effect of disable and blank, the first-pixel latency, and the ignoring of a restart mid-frame. The bench compares every pixel against a model of the memories built from the requirements.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CUR_DIM      = 64;
  localparam int PAT_W        = 16;
  localparam int CODE_W       = 2;
  localparam int RGB_W        = 24;
  localparam int IDX_W        = 8;
  localparam int CUR_COLORS   = (1 << CODE_W) - 1;
  localparam int DIM_B        = $clog2(CUR_DIM);
  localparam int PIX_PER_WORD = PAT_W / CODE_W;
  localparam int SEL_B        = $clog2(PIX_PER_WORD);
  localparam int PAT_AW       = DIM_B + (DIM_B - SEL_B);

  typedef logic [CODE_W-1:0] cur_code_t;
  typedef logic [SEL_B-1:0]  slot_t;

  function automatic cur_code_t code_of(input logic [PAT_W-1:0] word, input slot_t slot);
    cur_code_t c;
    c = '0;
    for (int i = 0; i < PIX_PER_WORD; i++) begin
      if (slot == slot_t'(i)) c = word[i*CODE_W +: CODE_W];
    end
    return c;
  endfunction
endpackage

// File: rtl/ovl_raster_scan.sv
module ovl_raster_scan #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_go,
  input  logic [XW-1:0] width,
  input  logic [YW-1:0] height,
  input  logic [AW-1:0] top,
  output logic          start,
  output logic          busy,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          last,
  output logic [AW-1:0] addr
);
  logic [XW-1:0] w_l;
  logic [YW-1:0] h_l;
  logic          row_end;

  assign start   = frame_go && !busy && (width != '0) && (height != '0);
  assign row_end = (x == w_l - 1'b1);
  assign last    = busy && row_end && (y == h_l - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      x    <= '0;
      y    <= '0;
      addr <= '0;
      w_l  <= '0;
      h_l  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      x    <= '0;
      y    <= '0;
      addr <= top;
      w_l  <= width;
      h_l  <= height;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (row_end) begin
        x <= '0;
        y <= y + 1'b1;
        if (last) busy <= 1'b0;
      end else begin
        x <= x + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_cursor_hit.sv
module ovl_cursor_hit
  import ovl_pkg::*;
#(
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic              enable,
  input  logic [XW-1:0]     x,
  input  logic [YW-1:0]     y,
  input  logic [XW-1:0]     cx,
  input  logic [YW-1:0]     cy,
  output logic              hit,
  output logic [PAT_AW-1:0] pat_addr,
  output slot_t             slot
);
  logic [XW:0] dx;
  logic [YW:0] dy;
  logic        in_x, in_y;

  always_comb begin
    dx       = {1'b0, x} - {1'b0, cx};
    dy       = {1'b0, y} - {1'b0, cy};
    in_x     = !dx[XW] && (dx[XW-1:0] < XW'(CUR_DIM));
    in_y     = !dy[YW] && (dy[YW-1:0] < YW'(CUR_DIM));
    hit      = enable && in_x && in_y;
    pat_addr = {dy[DIM_B-1:0], dx[DIM_B-1:SEL_B]};
    slot     = dx[SEL_B-1:0];
  end
endmodule

// File: rtl/ovl_pix_mix.sv
module ovl_pix_mix
  import ovl_pkg::*;
#(
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [XW-1:0]               in_x,
  input  logic [YW-1:0]               in_y,
  input  logic                        in_last,
  input  logic                        in_blank,
  input  cur_code_t                   in_code,
  input  logic [RGB_W-1:0]            pal_rgb,
  input  logic [CUR_COLORS*RGB_W-1:0] cur_colors,
  output logic                        out_valid,
  output logic [XW-1:0]               out_x,
  output logic [YW-1:0]               out_y,
  output logic [RGB_W-1:0]            out_rgb,
  output logic                        frame_irq
);
  localparam int TAB_N = 1 << CODE_W;

  logic [RGB_W-1:0] cur_tab [TAB_N];
  logic [RGB_W-1:0] mixed;
  logic             last_q;

  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    if (i < CUR_COLORS) begin : g_used
      assign cur_tab[i] = cur_colors[i*RGB_W +: RGB_W];
    end else begin : g_spare
      assign cur_tab[i] = '0;
    end
  end

  always_comb begin
    if (in_blank)             mixed = '0;
    else if (in_code == '0)   mixed = pal_rgb;
    else                      mixed = cur_tab[in_code - 1'b1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_rgb   <= '0;
      last_q    <= 1'b0;
      frame_irq <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_x     <= in_x;
      out_y     <= in_y;
      out_rgb   <= in_valid ? mixed : '0;
      last_q    <= in_valid && in_last;
      frame_irq <= last_q;
    end
  end
endmodule

// File: rtl/ovl_cursor_mixer.sv
module ovl_cursor_mixer
  import ovl_pkg::*;
#(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int AW = 20
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_go,
  input  logic [XW-1:0]               width,
  input  logic [YW-1:0]               height,
  input  logic [AW-1:0]               top_offset,
  input  logic [XW-1:0]               cursor_x,
  input  logic [YW-1:0]               cursor_y,
  input  logic                        cursor_off,
  input  logic                        force_blank,
  input  logic [CUR_COLORS*RGB_W-1:0] cur_colors,
  output logic [AW-1:0]               fb_addr,
  input  logic [IDX_W-1:0]            fb_data,
  output logic [PAT_AW-1:0]           pat_addr,
  input  logic [PAT_W-1:0]            pat_data,
  output logic [IDX_W-1:0]            pal_addr,
  input  logic [RGB_W-1:0]            pal_data,
  output logic                        out_valid,
  output logic [XW-1:0]               out_x,
  output logic [YW-1:0]               out_y,
  output logic [RGB_W-1:0]            out_rgb,
  output logic                        frame_irq
);
  // stage 0: scan position, addresses to frame memory and pattern
  logic          scan_start, scan_busy, scan_last;
  logic [XW-1:0] scan_x;
  logic [YW-1:0] scan_y;
  logic [XW-1:0] cx_l;
  logic [YW-1:0] cy_l;
  logic          off_l, blank_l;
  logic          hit0;
  slot_t         slot0;

  ovl_raster_scan #(.XW(XW), .YW(YW), .AW(AW)) scan_i (
    .clk(clk), .rst(rst), .frame_go(frame_go),
    .width(width), .height(height), .top(top_offset),
    .start(scan_start), .busy(scan_busy), .x(scan_x), .y(scan_y),
    .last(scan_last), .addr(fb_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cx_l    <= '0;
      cy_l    <= '0;
      off_l   <= 1'b1;
      blank_l <= 1'b0;
    end else if (scan_start) begin
      cx_l    <= cursor_x;
      cy_l    <= cursor_y;
      off_l   <= cursor_off;
      blank_l <= force_blank;
    end
  end

  ovl_cursor_hit #(.XW(XW), .YW(YW)) hit_i (
    .enable(!off_l), .x(scan_x), .y(scan_y), .cx(cx_l), .cy(cy_l),
    .hit(hit0), .pat_addr(pat_addr), .slot(slot0)
  );

  // stage 1: byte and pattern word arrive, palette is addressed
  logic          v1, last1, hit1, blank1;
  logic [XW-1:0] x1;
  logic [YW-1:0] y1;
  slot_t         slot1;
  cur_code_t     code1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; last1 <= 1'b0; hit1 <= 1'b0; blank1 <= 1'b0;
      x1 <= '0; y1 <= '0; slot1 <= '0;
    end else begin
      v1     <= scan_busy;
      last1  <= scan_last;
      hit1   <= hit0;
      blank1 <= blank_l;
      x1     <= scan_x;
      y1     <= scan_y;
      slot1  <= slot0;
    end
  end

  assign pal_addr = fb_data;
  assign code1    = hit1 ? code_of(pat_data, slot1) : '0;

  // stage 2: palette colour arrives, mixer registers the output
  logic          v2, last2, blank2;
  logic [XW-1:0] x2;
  logic [YW-1:0] y2;
  cur_code_t     code2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; last2 <= 1'b0; blank2 <= 1'b0;
      x2 <= '0; y2 <= '0; code2 <= '0;
    end else begin
      v2     <= v1;
      last2  <= last1;
      blank2 <= blank1;
      x2     <= x1;
      y2     <= y1;
      code2  <= code1;
    end
  end

  ovl_pix_mix #(.XW(XW), .YW(YW)) mix_i (
    .clk(clk), .rst(rst), .in_valid(v2), .in_x(x2), .in_y(y2),
    .in_last(last2), .in_blank(blank2), .in_code(code2),
    .pal_rgb(pal_data), .cur_colors(cur_colors),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_rgb(out_rgb), .frame_irq(frame_irq)
  );
endmodule

// File: rtl/ovl_cursor_mixer_chk.sv
module ovl_cursor_mixer_chk #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_go,
  input logic [XW-1:0] width,
  input logic [YW-1:0] height,
  input logic [AW-1:0] fb_addr,
  input logic          out_valid,
  input logic [XW-1:0] out_x,
  input logic          frame_irq,
  input logic          scan_busy
);
  // R2: frame memory is read linearly while a scan runs
  p_linear_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    scan_busy && $past(scan_busy) |-> fb_addr == $past(fb_addr) + 1'b1);

  // R2: columns step by one inside a line
  p_column_step_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) && out_x != '0 |-> out_x == $past(out_x) + 1'b1);

  // R8: the interrupt only follows a pixel strobe
  p_irq_after_pixel_r8: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> $past(out_valid));

  // R8: the interrupt is a single-cycle pulse
  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);

  // R9: a zero-sized request never starts a scan
  p_zero_size_r9: assert property (@(posedge clk) disable iff (rst)
    !scan_busy && frame_go && (width == '0 || height == '0) |=> !scan_busy);
endmodule

bind ovl_cursor_mixer ovl_cursor_mixer_chk #(.XW(XW), .YW(YW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .frame_go(frame_go), .width(width), .height(height),
  .fb_addr(fb_addr), .out_valid(out_valid), .out_x(out_x),
  .frame_irq(frame_irq), .scan_busy(scan_busy)
);

// File: tb/ovl_cursor_mixer_tb_top.sv
module ovl_cursor_mixer_tb_top;
  localparam int XW = 10;
  localparam int YW = 10;
  localparam int AW = 12;
  localparam int FB_N = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_go = 1'b0;
  logic [XW-1:0] width = '0;
  logic [YW-1:0] height = '0;
  logic [AW-1:0] top_offset = '0;
  logic [XW-1:0] cursor_x = '0;
  logic [YW-1:0] cursor_y = '0;
  logic          cursor_off = 1'b0;
  logic          force_blank = 1'b0;
  logic [71:0]   cur_colors;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_data;
  logic [8:0]    pat_addr;
  logic [15:0]   pat_data;
  logic [7:0]    pal_addr;
  logic [23:0]   pal_data;
  logic          out_valid;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;
  logic [23:0]   out_rgb;
  logic          frame_irq;

  always #4 clk = ~clk;

  ovl_cursor_mixer #(.XW(XW), .YW(YW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .frame_go(frame_go), .width(width), .height(height),
    .top_offset(top_offset), .cursor_x(cursor_x), .cursor_y(cursor_y),
    .cursor_off(cursor_off), .force_blank(force_blank), .cur_colors(cur_colors),
    .fb_addr(fb_addr), .fb_data(fb_data), .pat_addr(pat_addr), .pat_data(pat_data),
    .pal_addr(pal_addr), .pal_data(pal_data), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb), .frame_irq(frame_irq)
  );

  // synchronous memory models
  logic [7:0]  fb_mem  [FB_N];
  logic [23:0] pal_mem [256];
  logic [15:0] pat_mem [512];

  always @(posedge clk) begin
    fb_data  <= fb_mem[fb_addr];
    pat_data <= pat_mem[pat_addr];
    pal_data <= pal_mem[pal_addr];
  end

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // frame configuration as the bench believes it was sampled
  int e_w, e_h, e_top, e_cx, e_cy;
  bit e_off, e_blank;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns tag of the rule that decides the pixel and its colour
  function automatic logic [23:0] exp_pix(input int x, input int y, output string tag);
    int a, dx, dy, code;
    logic [15:0] word;
    bit win;
    a   = (e_top + y * e_w + x) % FB_N;
    dx  = x - e_cx;
    dy  = y - e_cy;
    win = (dx >= 0) && (dx < 64) && (dy >= 0) && (dy < 64);
    if (e_blank) begin tag = "R7"; return 24'h0; end
    if (!win) begin tag = "R3"; return pal_mem[fb_mem[a]]; end
    word = pat_mem[dy * 8 + dx / 8];
    code = (word >> ((dx % 8) * 2)) & 3;
    if (e_off) begin tag = "R6"; return pal_mem[fb_mem[a]]; end
    if (code == 0) begin tag = "R4"; return pal_mem[fb_mem[a]]; end
    tag = "R5";
    return cur_colors[24*(code-1) +: 24];
  endfunction

  task automatic run_frame(input int w, input int h, input int top, input int cx,
                           input int cy, input bit off, input bit blank, input int retrig_at);
    int k, n, lat, guard, total;
    bit early_irq;
    string tag;
    logic [23:0] e;
    width = XW'(w); height = YW'(h); top_offset = AW'(top);
    cursor_x = XW'(cx); cursor_y = YW'(cy); cursor_off = off; force_blank = blank;
    e_w = w; e_h = h; e_top = top; e_cx = cx; e_cy = cy; e_off = off; e_blank = blank;
    total = w * h;
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    n = 1; k = 0; lat = -1; guard = 0; early_irq = 1'b0;
    while (k < total && guard < total + 60) begin
      if (out_valid) begin
        if (k == 0) lat = n;
        check(out_x == XW'(k % w) && out_y == YW'(k / w), "R2 coordinates",
              {out_y, out_x}, {YW'(k / w), XW'(k % w)});
        e = exp_pix(k % w, k / w, tag);
        check(out_rgb == e, tag, out_rgb, e);
        k++;
      end
      if (frame_irq) early_irq = 1'b1;
      if (n == retrig_at) begin
        frame_go = 1'b1; width = XW'(w + 3); top_offset = AW'(top + 7); force_blank = ~blank;
      end else begin
        frame_go = 1'b0;
      end
      @(negedge clk);
      n++; guard++;
    end
    frame_go = 1'b0;
    check(k == total, "R10 pixel count", k, total);
    check(lat == 4, "R11 first-pixel latency", lat, 4);
    check(!early_irq, "R8 no interrupt inside frame", early_irq, 0);
    check(frame_irq == 1'b1 && out_valid == 1'b0, "R8 interrupt after last pixel", frame_irq, 1);
    @(negedge clk);
    check(frame_irq == 1'b0, "R8 interrupt single cycle", frame_irq, 0);
    for (int i = 0; i < 8; i++) begin
      if (out_valid) begin
        check(1'b0, "R10 stray pixel after frame", out_valid, 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic zero_frame(input int w, input int h);
    bit seen;
    seen = 1'b0;
    width = XW'(w); height = YW'(h);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (out_valid || frame_irq) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9 zero-size frame ignored", seen, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < FB_N; i++) fb_mem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) pal_mem[i] = 24'($urandom);
    for (int i = 0; i < 512; i++) pat_mem[i] = 16'($urandom & $urandom);
    cur_colors = {24'hA0B0C0, 24'h123456, 24'hFEDCBA};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(out_valid == 1'b0 && frame_irq == 1'b0, "R1 reset state", {out_valid, frame_irq}, 0);
      @(negedge clk);
    end

    // cursor clipped by the right screen edge, restart attempt mid-frame
    run_frame(40, 30, 100, 5, 3, 1'b0, 1'b0, 6);
    // cursor at origin, window edges at x/y 63 and 64 inside the screen
    run_frame(70, 66, 0, 0, 0, 1'b0, 1'b0, -1);
    // same geometry with the cursor disabled
    run_frame(70, 66, 0, 0, 0, 1'b1, 1'b0, -1);
    // forced blank while the cursor is enabled
    run_frame(30, 20, 55, 2, 2, 1'b0, 1'b1, 10);
    // fetch wraps around the end of frame memory
    run_frame(20, 10, FB_N - 6, 12, 4, 1'b0, 1'b0, -1);
    // cursor placed entirely off screen
    run_frame(25, 12, 9, 500, 3, 1'b0, 1'b0, -1);
    // single-pixel frame under the cursor
    run_frame(1, 1, 77, 0, 0, 1'b0, 1'b0, -1);
    zero_frame(0, 5);
    zero_frame(5, 0);

    for (int r = 0; r < 6; r++) begin
      run_frame(1 + int'($urandom % 90), 1 + int'($urandom % 70), int'($urandom % FB_N),
                int'($urandom % 100), int'($urandom % 80),
                ($urandom % 8) == 0, ($urandom % 8) == 0, int'($urandom % 20));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule